// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Divider Controller

This block divides a VCO-derived input clock by a programmable effective factor with quarter-step resolution. The 15-bit factor splits into two parts. The upper 13 bits give an integer ratio N, and the lower 2 bits give a fraction k. A down-counter ends each output period after N or N+1 input cycles. A 2-bit phase accumulator picks the longer period exactly k times in every 4 consecutive periods, so the average division is N + k/4.

Configuration arrives as a complete word with a one-cycle load strobe. After reset the block is silent until it accepts its first legal factor. Later factors wait in a shadow register. They are committed only on an output-pulse boundary at which the charge pump reports idle, so the frequency moves cleanly. A test-enable bit copies the divided pulse onto a monitor pin.

The controller has three states:
- `ST_HALT`: no valid factor yet.
- `ST_RUN`: a factor is active and nothing is waiting.
- `ST_PEND`: a factor is active and a newer one waits in the shadow register.

The transitions are:
- T_START: `ST_HALT`→`ST_RUN` on a legal load.
- T_STAGE: `ST_RUN`→`ST_PEND` on a legal load.
- T_COMMIT: `ST_PEND`→`ST_RUN` at a pulse boundary with the busy flag low.
- T_RESTAGE: `ST_PEND`→`ST_PEND` on a further legal load, or on a boundary while busy.

Top module: `fracn_div_ctrl`

## Requirements
- R1: After reset, `div_pulse`, `test_mon` and `cfg_reject` are low, and no pulse appears until a legal factor has been loaded.
- R2: The factor is split as N = `cfg_factor[14:2]` and k = `cfg_factor[1:0]`. Every output period, measured between consecutive pulses, lasts either N or N+1 input clock cycles.
- R3: Any 4 consecutive output periods add up to exactly 4·N + k input cycles.
- R4: The N+1 periods are spread evenly by the accumulator. With k=0 every period is N, and with k=2 long and short periods strictly alternate.
- R5: A load whose factor is below 2048 is ignored: the active setting and the output timing are unchanged. `cfg_reject` goes high for exactly one cycle, in the cycle after the load.
- R6: The first legal load from the halted state starts the divider at once. The first pulse appears on the N-th rising edge after the edge that captures the load.
- R7: In the running state, a new factor takes effect only at a pulse boundary. The period that begins at the first idle boundary after the load already uses the new factor. When several loads come before the commit, the latest one wins.
- R8: While `cp_busy` is high at a boundary, a pending factor is not applied, and the old ratio keeps running.
- R9: `test_mon` equals `div_pulse` while `test_en` is high, and is held low otherwise.
- R10: `div_pulse` is one input clock cycle wide. The counter reloads on the same edge, so no cycle is lost between periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (VCO-derived) |
| rst_n | input | 1 | Active-low power-up reset |
| cfg_factor | input | 15 | Effective division factor, 4·N + k |
| cfg_load | input | 1 | One-cycle strobe that marks a complete factor write |
| cp_busy | input | 1 | High while the charge pump sources or sinks current |
| test_en | input | 1 | Routes the divided pulse onto the monitor pin |
| div_pulse | output | 1 | Divided comparison pulse, one cycle per period |
| test_mon | output | 1 | Test monitor copy of the divided pulse |
| cfg_reject | output | 1 | One-cycle flag for a factor below the legal range |

## Verification
The assertions check several properties on every cycle:
- the halted state stays quiet;
- the active factor never drops below the minimum;
- the active factor holds still while the pump is busy or between boundaries;
- the pulse never lasts two cycles;
- the accumulator moves only when a period ends.

Some properties need whole periods to be measured, so only the bench scenarios show them:
- the exact lengths of the periods;
- the sum over four periods and the pattern of long periods;
- the delay of the first pulse;
- that the latest of several pending loads wins.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_PEND = 2'd2
    } fn_state_e;

endpackage

// File: rtl/fracn_seq.sv
module fracn_seq #(
    parameter int FRAC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    // the carry out of acc + frac requests one extra cycle
    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign carry = sum[FRAC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(acc_q)); // R4

endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt #(
    parameter int INT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic [INT_W-1:0] ratio,
    input  logic             extra,
    output logic             tc
);
    logic [INT_W-1:0] cnt_q;

    assign tc = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= ratio;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tc) begin
            cnt_q <= ratio - INT_W'(1) + INT_W'(extra);
        end else begin
            cnt_q <= cnt_q - INT_W'(1);
        end
    end

    AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc); // R10

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
    import fracn_pkg::*;
#(
    parameter int INT_W      = 13,
    parameter int FRAC_W     = 2,
    parameter int MIN_FACTOR = 2048
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [INT_W+FRAC_W-1:0] cfg_factor,
    input  logic                    cfg_load,
    input  logic                    cp_busy,
    input  logic                    test_en,
    output logic                    div_pulse,
    output logic                    test_mon,
    output logic                    cfg_reject
);
    localparam int FACT_W = INT_W + FRAC_W;

    fn_state_e         state_q, state_d;
    logic [FACT_W-1:0] active_q, shadow_q, use_val;
    logic              rej_q;
    logic              load_ok, start, commit, tc, carry;

    assign load_ok = cfg_load && (cfg_factor >= FACT_W'(MIN_FACTOR));
    assign start   = (state_q == ST_HALT) && load_ok;
    assign commit  = (state_q == ST_PEND) && tc && !cp_busy;
    assign use_val = start  ? cfg_factor :
                     commit ? shadow_q   : active_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (load_ok) state_d = ST_RUN;           // T_START
            ST_RUN:  if (load_ok) state_d = ST_PEND;          // T_STAGE
            ST_PEND: begin
                if (load_ok)     state_d = ST_PEND;           // T_RESTAGE
                else if (commit) state_d = ST_RUN;            // T_COMMIT
            end
            default: state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // factor registers and reject flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
            shadow_q <= '0;
            rej_q    <= 1'b0;
        end else begin
            rej_q <= cfg_load && !load_ok;
            if (start || commit) active_q <= use_val;
            if (load_ok && !start) shadow_q <= cfg_factor;
        end
    end

    // outputs
    always_comb begin
        div_pulse  = tc;
        test_mon   = test_en && tc;
        cfg_reject = rej_q;
    end

    fracn_cnt #(.INT_W(INT_W)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_HALT),
        .start (start),
        .ratio (use_val[FACT_W-1:FRAC_W]),
        .extra (carry),
        .tc    (tc)
    );

    fracn_seq #(.FRAC_W(FRAC_W)) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start),
        .step  (tc),
        .frac  (use_val[FRAC_W-1:0]),
        .carry (carry)
    );

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |-> (!div_pulse && !test_mon)); // R1
    AST_ACTIVE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HALT) |-> (active_q >= FACT_W'(MIN_FACTOR))); // R5
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HALT && cp_busy) |=> $stable(active_q)); // R8
    AST_COMMIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_HALT && !div_pulse) |=> $stable(active_q)); // R7

endmodule

// File: tb/test_fracn_div_ctrl.sv
module test_fracn_div_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cfg_factor = '0;
    logic        cfg_load = 1'b0;
    logic        cp_busy = 1'b0;
    logic        test_en = 1'b0;
    logic        div_pulse, test_mon, cfg_reject;

    int n_chk = 0, n_fail = 0, mon_fail = 0, pulses = 0;
    bit prev_pulse = 1'b0, done = 1'b0;

    always #5 clk = ~clk;

    fracn_div_ctrl i_fracn_div_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_factor(cfg_factor), .cfg_load(cfg_load),
        .cp_busy(cp_busy), .test_en(test_en), .div_pulse(div_pulse),
        .test_mon(test_mon), .cfg_reject(cfg_reject)
    );

    typedef struct packed {
        logic [14:0] f;
        logic [12:0] n;
        logic [1:0]  k;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{15'd2048, 13'd512,  2'd0},
        '{15'd2049, 13'd512,  2'd1},
        '{15'd2051, 13'd512,  2'd3},
        '{15'd2055, 13'd513,  2'd3},
        '{15'd32767,13'd8191, 2'd3},
        '{15'd2561, 13'd640,  2'd1},
        '{15'd3000, 13'd750,  2'd0},
        '{15'd4098, 13'd1024, 2'd2},
        '{15'd2050, 13'd512,  2'd2}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // counts negedges until one shows a pulse
    task automatic next_pulse(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!div_pulse);
    endtask

    task automatic load(input logic [14:0] f);
        @(negedge clk);
        cfg_factor = f;
        cfg_load   = 1'b1;
        @(negedge clk);
        cfg_load   = 1'b0;
    endtask

    task automatic four_periods(output int p [4]);
        for (int i = 0; i < 4; i++) next_pulse(p[i]);
    endtask

    // continuous monitor: pulse width (R10) and monitor pin (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (div_pulse && prev_pulse) begin
                mon_fail++;
                $display("FAIL R10 pulse width actual=2 expected=1");
            end
            if (test_mon !== (test_en && div_pulse)) begin
                mon_fail++;
                $display("FAIL R9 test_mon actual=%0d expected=%0d", test_mon, test_en && div_pulse);
            end
            if (div_pulse) pulses++;
        end
        prev_pulse = div_pulse;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            finish_run();
        end
    end

    initial begin
        int c, s, nl;
        int p [4];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!div_pulse && !test_mon && !cfg_reject, "R1 outputs after reset",
              {div_pulse, test_mon, cfg_reject}, 0);
        repeat (2000) @(negedge clk);
        check(pulses == 0, "R1 silent while halted", pulses, 0);

        // rejected load while halted
        load(15'd2047);
        check(cfg_reject == 1'b1, "R5 reject flag raised", cfg_reject, 1);
        @(negedge clk);
        check(cfg_reject == 1'b0, "R5 reject flag one cycle", cfg_reject, 0);
        repeat (1000) @(negedge clk);
        check(pulses == 0, "R5 illegal load does not start", pulses, 0);

        // first legal load
        @(negedge clk);
        cfg_factor = 15'd2049;
        cfg_load   = 1'b1;
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (c == 1) cfg_load = 1'b0;
        end while (!div_pulse);
        check(c == 513, "R6 first pulse delay", c, 513);

        // vector table
        foreach (VECS[v]) begin
            load(VECS[v].f);
            next_pulse(c);
            four_periods(p);
            s = 0;
            nl = 0;
            for (int i = 0; i < 4; i++) begin
                check(p[i] == int'(VECS[v].n) || p[i] == int'(VECS[v].n) + 1,
                      "R2 period is N or N+1", p[i], int'(VECS[v].n));
                s += p[i];
                if (p[i] == int'(VECS[v].n) + 1) nl++;
            end
            check(s == int'(VECS[v].f), "R3 four-period sum", s, int'(VECS[v].f));
            check(nl == int'(VECS[v].k), "R4 long-period count", nl, int'(VECS[v].k));
        end

        // k=2 alternation on the last vector (2050)
        four_periods(p);
        for (int i = 0; i < 3; i++)
            check(p[i] != p[i+1], "R4 alternation for k=2", p[i+1], 1 - p[i]);

        // deferral while busy, latest load wins
        @(negedge clk);
        cp_busy = 1'b1;
        load(15'd3001);
        next_pulse(c);
        four_periods(p);
        check(p[0]+p[1]+p[2]+p[3] == 2050, "R8 old ratio while busy",
              p[0]+p[1]+p[2]+p[3], 2050);
        load(15'd2563);
        next_pulse(c);
        cp_busy = 1'b0;
        four_periods(p);
        check(p[0]+p[1]+p[2]+p[3] == 2563, "R7 latest pending load committed",
              p[0]+p[1]+p[2]+p[3], 2563);

        // illegal load while running
        load(15'd1000);
        check(cfg_reject == 1'b1, "R5 reject while running", cfg_reject, 1);
        next_pulse(c);
        four_periods(p);
        check(p[0]+p[1]+p[2]+p[3] == 2563, "R5 running ratio unchanged",
              p[0]+p[1]+p[2]+p[3], 2563);

        // test monitor
        test_en = 1'b1;
        next_pulse(c);
        check(test_mon == 1'b1, "R9 monitor follows pulse", test_mon, 1);
        test_en = 1'b0;
        next_pulse(c);
        check(test_mon == 1'b0, "R9 monitor gated off", test_mon, 0);

        check(mon_fail == 0, "R9 R10 continuous monitor", mon_fail, 0);
        done = 1'b1;
        finish_run();
    end
endmodule